// File: doc/BRIEF.md
# SIR Oversampling Rate Generator

This block turns a 48 MHz reference clock into the two timing strobes a slow-rate infrared UART needs. One strobe marks sample points at sixteen times the bit rate. The other marks bit boundaries at the bit rate. Both are single-cycle enables in the reference clock domain.

The rate is set by three stages in series. A fixed divide-by-26 prescaler comes first. A programmable divider follows it, dividing by a 6-bit count plus one. A divide-by-16 stage comes last. The bit rate is therefore 48 MHz / 26 / (count + 1) / 16, and software picks the count as 48e6/26/16/rate - 1. A count of 11 gives 9600 bit/s.

The block also holds a 2-bit receive-timeout select. Only the values 0 to 2 can be stored in it, and it reads as zero while the link is not in slow-rate mode. A one-cycle request returns the count to its default rate.

Top module: `sir_rate_gen`

## Requirements
- R1: While reset is held and on release, `rate_count` is 11, `tmo_sel` is 0, and `sample_en` and `bit_en` are low.
- R2: The first `sample_en` pulse after reset release comes in the 26th clock cycle. Counting the release cycle as cycle 0, it falls in cycle 25.
- R3: Consecutive `sample_en` pulses are exactly 26*(N+1) clock cycles apart. N is the count in force when the earlier pulse fired. Each pulse lasts one cycle.
- R4: `bit_en` fires only together with `sample_en`, and does so on the 16th, 32nd, 48th and later sample pulses counted from reset. It lasts one cycle.
- R5: A write with `rate_wr` high loads bits 5:0 of `rate_wdata` into the count. Bits 15:6 have no effect. The new value is visible on `rate_count` in the cycle after the write.
- R6: A new count takes effect only at the next `sample_en` reload. The interval already in progress keeps its old length.
- R7: A pulse on `rate_default` sets the count to 11 (9600 bit/s). It wins over a `rate_wr` in the same cycle.
- R8: A write with `cfg_wr` high stores `cfg_wdata[9:8]` as the timeout select when that field is 0, 1 or 2. The value 3 is ignored and the old value is kept. Bits other than 9:8 have no effect.
- R9: `tmo_sel` reads 0 while `sir_mode` is low. The stored value is kept, and it reappears when `sir_mode` returns high.
- R10: The count range ends work: count 0 gives a sample period of 26 cycles, and count 63 gives 1664 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_wr | input | 1 | Write strobe for the baud-count word |
| rate_wdata | input | 16 | Baud-count word; count in bits 5:0 |
| rate_default | input | 1 | Return the count to 11 |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word; timeout select in bits 9:8 |
| sir_mode | input | 1 | High while the link runs in slow-rate mode |
| rate_count | output | 6 | Count currently programmed |
| tmo_sel | output | 2 | Effective receive-timeout select |
| sample_en | output | 1 | 16x oversampling enable pulse |
| bit_en | output | 1 | Bit-rate enable pulse |

## Verification
The bench measures the spacing between sample pulses against the count captured at the earlier pulse. This catches two faults: a design that applies a new count in the middle of an interval would shorten or stretch that interval, and an off-by-one in the reload would miss every period by 26 cycles.

Writes land at random offsets inside an interval, with random values in the ignored upper bits. A design that decoded the wrong field, or that let the write beat the default request, would read back the wrong count. The bench also tests both ends of the count range and the phase of the 16th pulse. Timeout writes include the illegal value 3 and toggles of the mode input, so storing 3 or losing the stored value while the mode is off would show up on `tmo_sel`.

// File: rtl/sir_rate_pkg.sv
// Shared constants for the slow-rate oversampling generator.
// Assumes a 48 MHz reference and 16-bit register words.
package sir_rate_pkg;
    localparam int PRESCALE   = 26;  // fixed reference divider
    localparam int OVERSAMPLE = 16;  // samples per bit
    localparam int CNT_W      = 6;   // programmable count width
    localparam int CNT_LSB    = 0;   // count field position in its word
    localparam int DEF_COUNT  = 11;  // 9600 bit/s
    localparam int TMO_W      = 2;   // timeout select width
    localparam int TMO_LSB    = 8;   // timeout field position
    localparam int TMO_MAX    = 2;   // highest legal timeout code
    localparam int WORD_W     = 16;  // register word width
endpackage

// File: rtl/sir_prescaler.sv
// Free-running modulo-DIV counter; emits a one-cycle tick on wrap.
// Assumes DIV >= 2.
module sir_prescaler #(
    parameter int DIV = 26
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = $clog2(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    // Wrap point decode.
    always_comb tick_o = (cnt_q == LAST);

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0));
    assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/sir_rate_div.sv
// Programmable divide-by-(count+1) on prescaler ticks. The count is
// sampled only at reload, so a change never cuts an interval short.
// Assumes tick_i is a one-cycle pulse.
module sir_rate_div #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             sample_o
);
    logic [CNT_W-1:0] left_q;

    // Terminal event: tick while nothing is left to count.
    always_comb sample_o = tick_i && (left_q == '0);

    // Reload on the terminal event, otherwise count ticks down.
    always_ff @(posedge clk) begin
        if (!rst_n)        left_q <= '0;
        else if (sample_o) left_q <= count_i;
        else if (tick_i)   left_q <= left_q - 1'b1;
    end

    assert_sample_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> tick_i);
    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> (left_q == $past(count_i)));
endmodule

// File: rtl/sir_oversample_div.sv
// Divides sample enables by RATIO to give the bit enable, which
// coincides with every RATIO-th sample enable. Assumes RATIO >= 2.
module sir_oversample_div #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    output logic bit_o
);
    localparam int W = $clog2(RATIO);
    localparam logic [W-1:0] LAST = W'(RATIO - 1);

    logic [W-1:0] sub_q;

    // Last sample of a bit.
    always_comb bit_o = sample_i && (sub_q == LAST);

    // Advance once per sample enable.
    always_ff @(posedge clk) begin
        if (!rst_n)        sub_q <= '0;
        else if (bit_o)    sub_q <= '0;
        else if (sample_i) sub_q <= sub_q + 1'b1;
    end

    assert_bit_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_o |=> !bit_o);
    assert_bit_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_o |=> (sub_q == '0));
endmodule

// File: rtl/sir_rate_cfg.sv
// Holds the divider count and the receive-timeout select. Illegal
// timeout codes are dropped; the select reads 0 outside slow-rate mode.
// Assumes one-cycle write strobes.
module sir_rate_cfg #(
    parameter int WORD_W    = 16,
    parameter int CNT_W     = 6,
    parameter int CNT_LSB   = 0,
    parameter int DEF_COUNT = 11,
    parameter int TMO_W     = 2,
    parameter int TMO_LSB   = 8,
    parameter int TMO_MAX   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_wr_i,
    input  logic [WORD_W-1:0] rate_wdata_i,
    input  logic              rate_default_i,
    input  logic              cfg_wr_i,
    input  logic [WORD_W-1:0] cfg_wdata_i,
    input  logic              sir_mode_i,
    output logic [CNT_W-1:0]  rate_count_o,
    output logic [TMO_W-1:0]  tmo_sel_o
);
    localparam logic [CNT_W-1:0] DEF  = CNT_W'(DEF_COUNT);
    localparam logic [TMO_W-1:0] TMAX = TMO_W'(TMO_MAX);

    logic [CNT_W-1:0] count_q;
    logic [TMO_W-1:0] tmo_q;
    logic [CNT_W-1:0] count_field;
    logic [TMO_W-1:0] tmo_field;

    // Field extraction from the written words.
    always_comb begin
        count_field = rate_wdata_i[CNT_LSB +: CNT_W];
        tmo_field   = cfg_wdata_i[TMO_LSB +: TMO_W];
    end

    // Count register; the default request has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)              count_q <= DEF;
        else if (rate_default_i) count_q <= DEF;
        else if (rate_wr_i)      count_q <= count_field;
    end

    // Timeout register; only legal codes are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                               tmo_q <= '0;
        else if (cfg_wr_i && (tmo_field <= TMAX)) tmo_q <= tmo_field;
    end

    // Outputs: count readback, timeout gated by mode.
    always_comb begin
        rate_count_o = count_q;
        tmo_sel_o    = sir_mode_i ? tmo_q : '0;
    end

    assert_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rate_default_i |=> (rate_count_o == DEF));
    assert_rate_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_wr_i && !rate_default_i) |=>
            (rate_count_o == $past(rate_wdata_i[CNT_LSB +: CNT_W])));
    assert_tmo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && (cfg_wdata_i[TMO_LSB +: TMO_W] > TMAX)) |=> $stable(tmo_q));
    assert_tmo_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q <= TMAX);
    assert_tmo_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sir_mode_i |-> (tmo_sel_o == '0));
endmodule

// File: rtl/sir_rate_gen.sv
// Top of the slow-rate oversampling generator: prescaler, programmable
// divider and divide-by-16 in series, plus the configuration fields.
// Assumes clk is the 48 MHz reference.
module sir_rate_gen
    import sir_rate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rate_wr,
    input  logic [15:0] rate_wdata,
    input  logic        rate_default,
    input  logic        cfg_wr,
    input  logic [15:0] cfg_wdata,
    input  logic        sir_mode,
    output logic [5:0]  rate_count,
    output logic [1:0]  tmo_sel,
    output logic        sample_en,
    output logic        bit_en
);
    logic pre_tick;

    sir_rate_cfg #(
        .WORD_W(WORD_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB),
        .DEF_COUNT(DEF_COUNT), .TMO_W(TMO_W), .TMO_LSB(TMO_LSB),
        .TMO_MAX(TMO_MAX)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .rate_wr_i(rate_wr), .rate_wdata_i(rate_wdata),
        .rate_default_i(rate_default),
        .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
        .sir_mode_i(sir_mode),
        .rate_count_o(rate_count), .tmo_sel_o(tmo_sel)
    );

    sir_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_o(pre_tick)
    );

    sir_rate_div #(.CNT_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_i(pre_tick),
        .count_i(rate_count), .sample_o(sample_en)
    );

    sir_oversample_div #(.RATIO(OVERSAMPLE)) u_bit (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_en), .bit_o(bit_en)
    );

    assert_bit_with_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |-> sample_en);
    assert_sample_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> !sample_en);
endmodule

// File: tb/test_sir_rate_gen.sv
module test_sir_rate_gen;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_wr = 1'b0;
    logic [15:0] rate_wdata = '0;
    logic        rate_default = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        sir_mode = 1'b1;
    logic [5:0]  rate_count;
    logic [1:0]  tmo_sel;
    logic        sample_en;
    logic        bit_en;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int cyc = 0;
    int last_samp = -1;
    int nsamp = 0;
    int cur_period = 11;
    int shadow_count = 11;
    int shadow_tmo = 0;
    bit running = 1'b0;

    always #4 clk = ~clk;

    sir_rate_gen i_sir_rate_gen (
        .clk(clk), .rst_n(rst_n),
        .rate_wr(rate_wr), .rate_wdata(rate_wdata), .rate_default(rate_default),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .sir_mode(sir_mode),
        .rate_count(rate_count), .tmo_sel(tmo_sel),
        .sample_en(sample_en), .bit_en(bit_en)
    );

    function automatic int exp_interval(int n);
        return 26 * (n + 1);
    endfunction

    function automatic int exp_tmo(int stored, bit mode);
        return mode ? stored : 0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Per-cycle observation of the pulse outputs at the falling edge.
    task automatic monitor();
        cyc++;
        if (sample_en) begin
            if (last_samp < 0)
                check(cyc == 25, "R2 first sample cycle", cyc, 25);
            else
                check(cyc - last_samp == exp_interval(cur_period),
                      "R3/R6/R10 sample interval", cyc - last_samp,
                      exp_interval(cur_period));
            last_samp  = cyc;
            cur_period = shadow_count;
            nsamp++;
            check(bit_en == ((nsamp % 16) == 0), "R4 bit phase", int'(bit_en),
                  int'((nsamp % 16) == 0));
        end else if (bit_en) begin
            check(1'b0, "R4 bit without sample", 1, 0);
        end
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (running) monitor();
            rate_wr = 1'b0;
            rate_default = 1'b0;
            cfg_wr = 1'b0;
        end
    endtask

    task automatic write_rate(logic [15:0] w);
        rate_wr = 1'b1;
        rate_wdata = w;
        shadow_count = int'(w[5:0]);
        run(1);
        check(rate_count == 6'(shadow_count), "R5 count readback",
              int'(rate_count), shadow_count);
    endtask

    task automatic write_cfg(logic [15:0] w);
        cfg_wr = 1'b1;
        cfg_wdata = w;
        if (int'(w[9:8]) <= 2) shadow_tmo = int'(w[9:8]);
        run(1);
        check(tmo_sel == 2'(exp_tmo(shadow_tmo, sir_mode)), "R8 timeout select",
              int'(tmo_sel), exp_tmo(shadow_tmo, sir_mode));
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (4) begin
            @(negedge clk);
            check(!sample_en && !bit_en, "R1 no pulses in reset",
                  int'(sample_en) + int'(bit_en), 0);
        end
        check(rate_count == 6'd11, "R1 reset count", int'(rate_count), 11);
        check(tmo_sel == 2'd0, "R1 reset timeout", int'(tmo_sel), 0);
        rst_n = 1'b1;
        cyc = 0;
        running = 1'b1;
        run(26 * 12 * 20);

        // R5/R10: count 0 with junk upper bits
        write_rate(16'hFFC0);
        run(26 * 40);
        // R10: count 63
        write_rate(16'hAB3F);
        run(1664 * 3);
        // R7: default beats a simultaneous write
        rate_wr = 1'b1;
        rate_wdata = 16'h0005;
        rate_default = 1'b1;
        shadow_count = 11;
        run(1);
        check(rate_count == 6'd11, "R7 default priority", int'(rate_count), 11);
        run(312 * 3);

        // R6: random counts written at random phases
        for (int it = 0; it < 24; it++) begin
            logic [15:0] w;
            w = 16'($urandom());
            w[5:0] = 6'($urandom_range(0, 15));
            run(int'($urandom_range(1, 400)));
            write_rate(w);
            run(26 * 16 * 3);
        end
        rate_default = 1'b1;
        shadow_count = 11;
        run(1);
        check(rate_count == 6'd11, "R7 default alone", int'(rate_count), 11);
        run(312 * 18);

        // R8/R9: timeout select
        write_cfg(16'hF2FF);          // field 2
        write_cfg(16'h0300);          // field 3 ignored
        check(tmo_sel == 2'd2, "R8 illegal ignored", int'(tmo_sel), 2);
        write_cfg(16'h5D00 | 16'h0100 & 16'hFDFF); // field 1
        sir_mode = 1'b0;
        run(1);
        check(tmo_sel == 2'd0, "R9 gated when off", int'(tmo_sel), 0);
        write_cfg(16'h0200);          // field 2 stored while off
        check(tmo_sel == 2'd0, "R9 still gated", int'(tmo_sel), 0);
        sir_mode = 1'b1;
        run(1);
        check(tmo_sel == 2'd2, "R9 value kept", int'(tmo_sel), 2);
        for (int it = 0; it < 12; it++) begin
            write_cfg(16'($urandom()));
            sir_mode = 1'($urandom_range(0, 1));
            run(1);
            check(tmo_sel == 2'(exp_tmo(shadow_tmo, sir_mode)), "R9 random mode",
                  int'(tmo_sel), exp_tmo(shadow_tmo, sir_mode));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule